// File: doc/BRIEF.md
# Programmable 16-bit reload down-timer

This block is a 16-bit down-counter with a two-word register port. The count can be driven by one of three internal prescaled rates, which divide the clock by 2, 8 or 32. It can instead be driven by chosen edges of an external event input, which first passes through a two-flop synchronizer. The counter only runs after software sets the run bit and fires a trigger. The trigger copies the stored reload value into the counter.

An underflow is the step from 0000h to FFFFh, so one period spans reload value + 1 count steps. In auto-reload mode the counter takes the reload value again on every underflow and keeps running. In single-shot mode it stays at FFFFh and halts until the next trigger. Each underflow sets a sticky flag. The flag can raise an interrupt request and can toggle an output pin whose polarity is selectable.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the control word reads 0000h, and `irq` and `tmr_out` are low.
- R2: Select codes 00, 01 and 10 (control bits 10:9) count once every 2, 8 and 32 clocks. In auto-reload mode the underflow period is therefore (reload+1) times that divisor, measured in clocks.
- R3: An underflow happens on a count step taken at 0000h. In auto-reload mode (control bit 4 = 1) the counter takes the reload value and keeps counting. In single-shot mode it becomes FFFFh and ignores further count steps.
- R4: A control write with bit 0 (trigger) = 1 and bit 1 (run) = 1 loads the reload value into the counter and starts it. A trigger written with run = 0 leaves the counter unchanged. Bit 0 always reads as 0.
- R5: Select code 11 chooses event mode. Edge code (control bits 8:7) 01 counts rising edges, 10 counts falling edges, 11 counts both edges and 00 counts none. Edges are seen after a two-flop synchronizer.
- R6: The underflow flag (control bit 2) is sticky. Writing 0 clears it and writing 1 has no effect. An underflow in the same cycle as a clear leaves it set.
- R7: `irq` is high exactly while the flag and the interrupt enable (control bit 3) are both 1.
- R8: When output enable (control bit 6) is 1, each underflow toggles an internal level, and `tmr_out` shows that level inverted when bit 5 is 1. While bit 6 is 0, `tmr_out` is low and underflows do not toggle the level.
- R9: Address 1 writes the reload register without changing the live count, and reads return the live count. Address 0 reads and writes the control word.
- R10: Writing run = 0 halts counting. The count holds until the block is triggered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | 0 = control word, 1 = count/reload |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| evt_in | input | 1 | External event input |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Timer output pin |

## Verification
A corrupted count shows on the next read of address 1. It also moves the next underflow, which appears as a wrong `tmr_out` period or as the flag and `irq` rising one or more count steps early or late. A lost or stuck run/active state shows as a count that fails to move after an event pulse, within four clocks of the edge. A wrong flag priority shows as a flag that reads 0 right after a clear that collides with an underflow.

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int W  = 16,
  parameter int L0 = 1,
  parameter int L1 = 3,
  parameter int PW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         evt_in,
  output logic         irq,
  output logic         tmr_out
);
  localparam int CW = 11;

  logic [PW-1:0] pre;
  logic [2:0]    sync;
  logic [W-1:0]  cnt, reload_q;
  logic          active, tog;
  logic          run_en, flag, irq_en, auto_rl, out_inv, out_en;
  logic [1:0]    edge_sel, src_sel;
  logic          tick, evt_hit, ctrl_wr, rl_wr, trig, step, uf_evt;

  wire rise = sync[1] & ~sync[2];
  wire fall = ~sync[1] & sync[2];

  always_comb begin
    case (edge_sel)
      2'b01:   evt_hit = rise;
      2'b10:   evt_hit = fall;
      2'b11:   evt_hit = rise | fall;
      default: evt_hit = 1'b0;
    endcase
    case (src_sel)
      2'b00:   tick = &pre[L0-1:0];
      2'b01:   tick = &pre[L1-1:0];
      2'b10:   tick = &pre;
      default: tick = evt_hit;
    endcase
  end

  assign ctrl_wr = bus_wr & ~bus_addr;
  assign rl_wr   = bus_wr & bus_addr;
  assign trig    = ctrl_wr & bus_wdata[0] & bus_wdata[1];
  assign step    = active & run_en & tick;
  assign uf_evt  = step & (cnt == '0) & ~trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      sync <= '0;
    end else begin
      pre  <= pre + 1'b1;
      sync <= {sync[1:0], evt_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0; irq_en <= 1'b0; auto_rl <= 1'b0;
      out_inv <= 1'b0; out_en <= 1'b0;
      edge_sel <= '0; src_sel <= '0;
    end else if (ctrl_wr) begin
      run_en   <= bus_wdata[1];
      irq_en   <= bus_wdata[3];
      auto_rl  <= bus_wdata[4];
      out_inv  <= bus_wdata[5];
      out_en   <= bus_wdata[6];
      edge_sel <= bus_wdata[8:7];
      src_sel  <= bus_wdata[10:9];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      flag     <= 1'b0;
      tog      <= 1'b0;
    end else begin
      if (rl_wr) reload_q <= bus_wdata;

      if (trig)                       cnt <= reload_q;
      else if (step)                  cnt <= (cnt == '0 && auto_rl) ? reload_q : cnt - 1'b1;

      if (trig)                       active <= 1'b1;
      else if (ctrl_wr && !bus_wdata[1]) active <= 1'b0;
      else if (uf_evt && !auto_rl)    active <= 1'b0;

      if (uf_evt)                     flag <= 1'b1;
      else if (ctrl_wr && !bus_wdata[2]) flag <= 1'b0;

      if (uf_evt && out_en)           tog <= ~tog;
    end
  end

  assign bus_rdata = bus_addr ? cnt
                   : {{(W-CW){1'b0}}, src_sel, edge_sel, out_en, out_inv,
                      auto_rl, irq_en, flag, run_en, 1'b0};
  assign irq     = flag & irq_en;
  assign tmr_out = out_en & (tog ^ out_inv);

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0 && !trig) |=> (cnt == $past(cnt) - 1'b1));
  a_r3_reload_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && auto_rl) |=> (cnt == $past(reload_q)));
  a_r3_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !auto_rl) |=> (!active && cnt == '1));
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(uf_evt));
  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !trig) |=> $stable(cnt));
endmodule

// File: tb/reload_down_timer_tb.sv
module reload_down_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, evt_in = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, tmr_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  reload_down_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq), .tmr_out(tmr_out));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit trg, run, flg, ie, rl, inv, oe,
                                     input bit [1:0] edg, input bit [1:0] src);
    return {5'b0, src, edg, oe, inv, rl, ie, flg, run, trg};
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); evt_in = 1'b1;
    repeat (4) @(negedge clk);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(1'b0, d);
    check("R1 ctrl", d, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 out", tmr_out, 1'b0);
  endtask

  task automatic t_trigger_and_edges();
    logic [15:0] d;
    wr(1'b1, 16'h0010);
    rd(1'b1, d); check("R9 reload write keeps count", d, 16'h0000);
    wr(1'b0, cw(1,0,1,0,0,0,0,2'b00,2'b11));
    rd(1'b1, d); check("R4 trigger without run", d, 16'h0000);
    wr(1'b0, cw(1,1,1,0,0,0,0,2'b00,2'b11));
    rd(1'b1, d); check("R4 trigger loads", d, 16'h0010);
    rd(1'b0, d); check("R4 trigger reads 0", d[1:0], 2'b10);
    pulse(); rd(1'b1, d); check("R5 edge code 00", d, 16'h0010);
    wr(1'b0, cw(0,1,1,0,0,0,0,2'b01,2'b11));
    pulse(); rd(1'b1, d); check("R5 rising", d, 16'h000F);
    wr(1'b0, cw(0,1,1,0,0,0,0,2'b10,2'b11));
    pulse(); rd(1'b1, d); check("R5 falling", d, 16'h000E);
    wr(1'b0, cw(0,1,1,0,0,0,0,2'b11,2'b11));
    pulse(); rd(1'b1, d); check("R5 both edges", d, 16'h000C);
    rd(1'b0, d); check("R6 writing 1 does not set flag", d[2], 1'b0);
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    wr(1'b1, 16'h0002);
    wr(1'b0, cw(1,1,1,0,0,0,0,2'b01,2'b11));
    pulse(); pulse();
    rd(1'b1, d); check("R3 count reaches 0", d, 16'h0000);
    rd(1'b0, d); check("R3 no flag at 0", d[2], 1'b0);
    pulse();
    rd(1'b1, d); check("R3 single-shot wraps", d, 16'hFFFF);
    rd(1'b0, d); check("R6 flag set", d[2], 1'b1);
    pulse();
    rd(1'b1, d); check("R3 single-shot halted", d, 16'hFFFF);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    check("R7 irq masked", irq, 1'b0);
    wr(1'b0, cw(0,1,1,1,0,0,0,2'b01,2'b11));
    #1 check("R7 irq raised", irq, 1'b1);
    rd(1'b0, d); check("R6 write 1 keeps flag", d[2], 1'b1);
    wr(1'b0, cw(0,1,0,1,0,0,0,2'b01,2'b11));
    rd(1'b0, d); check("R6 write 0 clears", d[2], 1'b0);
    check("R7 irq dropped", irq, 1'b0);
  endtask

  task automatic t_reload_and_priority();
    logic [15:0] d;
    wr(1'b1, 16'h0001);
    wr(1'b0, cw(1,1,1,0,1,0,0,2'b01,2'b11));
    pulse(); pulse();
    rd(1'b1, d); check("R3 auto-reload", d, 16'h0001);
    rd(1'b0, d); check("R3 flag on reload", d[2], 1'b1);
    wr(1'b0, cw(0,1,0,0,1,0,0,2'b01,2'b11));
    pulse();
    rd(1'b1, d); check("R3 count at 0", d, 16'h0000);
    @(negedge clk); evt_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 1'b0; bus_wdata = cw(0,1,0,0,1,0,0,2'b01,2'b11); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; evt_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(1'b0, d); check("R6 set beats clear", d[2], 1'b1);
    rd(1'b1, d); check("R3 reloaded at collision", d, 16'h0001);
    wr(1'b0, cw(0,0,1,0,1,0,0,2'b01,2'b11));
    pulse();
    rd(1'b1, d); check("R10 run off holds", d, 16'h0001);
  endtask

  task automatic t_output();
    wr(1'b1, 16'h0000);
    wr(1'b0, cw(1,1,1,0,1,0,1,2'b01,2'b11));
    check("R8 start low", tmr_out, 1'b0);
    pulse(); check("R8 toggle high", tmr_out, 1'b1);
    pulse(); check("R8 toggle low", tmr_out, 1'b0);
    wr(1'b0, cw(0,1,1,0,1,1,1,2'b01,2'b11));
    check("R8 inverted", tmr_out, 1'b1);
    wr(1'b0, cw(0,1,1,0,1,1,0,2'b01,2'b11));
    check("R8 disabled low", tmr_out, 1'b0);
    pulse();
    wr(1'b0, cw(0,1,1,0,1,0,1,2'b01,2'b11));
    check("R8 no toggle while disabled", tmr_out, 1'b0);
  endtask

  task automatic t_prescale(input bit [1:0] src, input logic [15:0] rl, input int exp);
    int n;
    logic p;
    wr(1'b1, rl);
    wr(1'b0, cw(1,1,1,0,1,0,1,2'b00,src));
    p = tmr_out;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (tmr_out != p) break; end
    p = tmr_out; n = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); n++; if (tmr_out != p) break; end
    check($sformatf("R2 period src=%0d", src), n, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_trigger_and_edges();
    t_oneshot();
    t_irq();
    t_reload_and_priority();
    t_output();
    t_prescale(2'b00, 16'd4, 10);
    t_prescale(2'b01, 16'd3, 32);
    t_prescale(2'b10, 16'd1, 64);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule